// File: doc/BRIEF.md
# Maskable Event Status Unit with Force View

This block collects single-cycle event pulses from two independent paths, a receive path and a transmit path, into sticky status bits. Each path has its own mask register and a second, write-to-force address onto the same status storage. One level-sensitive interrupt output goes high while any unmasked status bit of either path is set.

Software reaches the block through a single-cycle register port made of a write strobe, a read strobe, a word address and data. A bit is cleared by writing 1 to it at the path's status address. Writing 1 to the same bit at the force address sets it. Both addresses read back the same stored value.

Each path has an enable input. While it is low, hardware events of that path are not latched, and bits that are already set stay set. The receive path carries nine events and the transmit path three. In both, the lowest bit is the frame-completed event and the higher bits are counter-overflow events.

Top module: `evt_irq_unit`

## Requirements
- R1: While a path's enable is 1, an event pulse on input bit i sets status bit i of that path at the next clock edge, and the bit stays set until software clears it.
- R2: Writing to a path's status address clears every status bit whose write-data bit is 1. Status bits whose write-data bit is 0 are unchanged.
- R3: Writing 1 to bit i at a path's force address sets status bit i whatever the enable is. Reading the force address returns the same value as reading the status address, and a clear at the status address is seen at both.
- R4: After reset, every status bit is 0, every implemented mask bit is 1 and the interrupt output is 0. A write to a mask address replaces the mask, and a mask bit of 1 keeps that status bit out of the interrupt.
- R5: The interrupt output is registered. It equals the OR over both paths of (status AND NOT mask) as held one clock earlier.
- R6: While a path's enable is 0, its event inputs leave status unchanged, and bits already set are kept.
- R7: If an event and a status-address write with 1 hit the same bit in the same cycle, the bit ends up set.
- R8: Read data is registered. It is valid on the cycle after the read strobe and is 0 on every cycle that follows no read strobe. Unused addresses (3 and 7) read 0 and ignore writes. Bits above a path's event count read 0 and are ignored on write.
- R9: Word addresses are: 0 receive status, 1 receive mask, 2 receive force, 4 transmit status, 5 transmit mask, 6 transmit force. Bit 0 of each path is the frame event. The receive path uses bits 8:0 and the transmit path uses bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive path enable |
| tx_en | input | 1 | Transmit path enable |
| rx_evt | input | RX_N | Receive event pulses |
| tx_evt | input | TX_N | Transmit event pulses |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register word address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with its defaults: nine receive events, three transmit events, 16-bit data and a 3-bit address. With these values the top receive bit (8) can be forced and cleared, bits 15:9 are reserved in both paths, and both unused addresses exist. A random phase mixes enables, events, masks, forces and clears on both paths against a behavioural model. This makes same-cycle set and clear, and masked-versus-unmasked transitions of the interrupt, frequent.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned OFF_STAT = 0;
  localparam int unsigned OFF_MASK = 1;
  localparam int unsigned OFF_FORCE = 2;
  localparam int unsigned RX_BASE = 0;
  localparam int unsigned TX_BASE = 4;

  typedef enum logic [1:0] {VIEW_STAT, VIEW_MASK, VIEW_FORCE, VIEW_NONE} view_e;

  function automatic view_e decode_view(input logic [31:0] a, input int unsigned base);
    if (a == base + OFF_STAT) return VIEW_STAT;
    if (a == base + OFF_MASK) return VIEW_MASK;
    if (a == base + OFF_FORCE) return VIEW_FORCE;
    return VIEW_NONE;
  endfunction
endpackage

// File: rtl/evt_irq_group.sv
module evt_irq_group #(
  parameter int unsigned N = 9,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned BASE = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              path_en,
  input  logic [N-1:0]      evt,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      wbits,
  output logic [N-1:0]      status,
  output logic [N-1:0]      mask,
  output logic [DATA_W-1:0] rd_val
);
  import evt_irq_pkg::*;

  view_e view;
  logic wr_stat, wr_mask, wr_force;
  logic [N-1:0] set_v, clr_v, status_q, mask_q;

  assign view = decode_view(32'(addr), BASE);
  assign wr_stat = wr && (view == VIEW_STAT);
  assign wr_mask = wr && (view == VIEW_MASK);
  assign wr_force = wr && (view == VIEW_FORCE);

  // per-bit set/clear terms; a set outranks a clear
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign set_v[i] = (path_en && evt[i]) || (wr_force && wbits[i]);
    assign clr_v[i] = wr_stat && wbits[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      mask_q <= '1;
    end else begin
      status_q <= (status_q & ~clr_v) | set_v;
      if (wr_mask) mask_q <= wbits;
    end
  end

  always_comb begin
    case (view)
      VIEW_STAT, VIEW_FORCE: rd_val = DATA_W'(status_q);
      VIEW_MASK: rd_val = DATA_W'(mask_q);
      default: rd_val = '0;
    endcase
  end

  assign status = status_q;
  assign mask = mask_q;
endmodule

// File: rtl/evt_irq_out.sv
module evt_irq_out #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd,
  input  logic [DATA_W-1:0] rd_val,
  input  logic              pend,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      irq <= 1'b0;
    end else begin
      rdata <= rd ? rd_val : '0;
      irq <= pend;
    end
  end
endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit #(
  parameter int unsigned RX_N = 9,
  parameter int unsigned TX_N = 3,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_en,
  input  logic              tx_en,
  input  logic [RX_N-1:0]   rx_evt,
  input  logic [TX_N-1:0]   tx_evt,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  import evt_irq_pkg::*;

  localparam int unsigned WIDEST = (RX_N > TX_N) ? RX_N : TX_N;

  logic [RX_N-1:0] rx_status, rx_mask;
  logic [TX_N-1:0] tx_status, tx_mask;
  logic [DATA_W-1:0] rx_rd, tx_rd;
  logic pend;

  evt_irq_group #(.N(RX_N), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE(RX_BASE)) u_rx (
    .clk(clk), .rst(rst), .path_en(rx_en), .evt(rx_evt), .wr(reg_wr),
    .addr(reg_addr), .wbits(reg_wdata[RX_N-1:0]),
    .status(rx_status), .mask(rx_mask), .rd_val(rx_rd)
  );

  evt_irq_group #(.N(TX_N), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE(TX_BASE)) u_tx (
    .clk(clk), .rst(rst), .path_en(tx_en), .evt(tx_evt), .wr(reg_wr),
    .addr(reg_addr), .wbits(reg_wdata[TX_N-1:0]),
    .status(tx_status), .mask(tx_mask), .rd_val(tx_rd)
  );

  // reserved write-data bits are discarded
  if (DATA_W > WIDEST) begin : g_resv
    logic wdata_unused;
    assign wdata_unused = ^reg_wdata[DATA_W-1:WIDEST];
  end

  assign pend = (|(rx_status & ~rx_mask)) | (|(tx_status & ~tx_mask));

  evt_irq_out #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .rd(reg_rd), .rd_val(rx_rd | tx_rd),
    .pend(pend), .rdata(reg_rdata), .irq(irq)
  );
endmodule

// File: rtl/evt_irq_unit_chk.sv
module evt_irq_unit_chk #(
  parameter int unsigned RX_N = 9,
  parameter int unsigned TX_N = 3,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_en,
  input logic              tx_en,
  input logic [RX_N-1:0]   rx_evt,
  input logic [TX_N-1:0]   tx_evt,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq,
  input logic [RX_N-1:0]   rx_status,
  input logic [RX_N-1:0]   rx_mask,
  input logic [TX_N-1:0]   tx_status,
  input logic [TX_N-1:0]   tx_mask
);
  import evt_irq_pkg::*;

  localparam logic [ADDR_W-1:0] A_RX_STAT = ADDR_W'(RX_BASE + OFF_STAT);
  localparam logic [ADDR_W-1:0] A_RX_FORCE = ADDR_W'(RX_BASE + OFF_FORCE);
  localparam logic [ADDR_W-1:0] A_TX_STAT = ADDR_W'(TX_BASE + OFF_STAT);
  localparam logic [ADDR_W-1:0] A_TX_FORCE = ADDR_W'(TX_BASE + OFF_FORCE);

  p_rx_evt_sets_r1: assert property (@(posedge clk) disable iff (rst)
    rx_en |=> ((rx_status & $past(rx_evt)) == $past(rx_evt)));
  p_tx_evt_sets_r1: assert property (@(posedge clk) disable iff (rst)
    tx_en |=> ((tx_status & $past(tx_evt)) == $past(tx_evt)));
  p_set_beats_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (rx_en && reg_wr && reg_addr == A_RX_STAT) |=> ((rx_status & $past(rx_evt)) == $past(rx_evt)));
  p_rx_force_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_RX_FORCE) |=>
      ((rx_status & $past(reg_wdata[RX_N-1:0])) == $past(reg_wdata[RX_N-1:0])));
  p_tx_force_r3: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == A_TX_FORCE) |=>
      ((tx_status & $past(reg_wdata[TX_N-1:0])) == $past(reg_wdata[TX_N-1:0])));
  p_rx_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!rx_en && !(reg_wr && (reg_addr == A_RX_STAT || reg_addr == A_RX_FORCE))) |=> $stable(rx_status));
  p_tx_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!tx_en && !(reg_wr && (reg_addr == A_TX_STAT || reg_addr == A_TX_FORCE))) |=> $stable(tx_status));
  p_irq_high_r5: assert property (@(posedge clk) disable iff (rst)
    ((|(rx_status & ~rx_mask)) || (|(tx_status & ~tx_mask))) |=> irq);
  p_irq_low_r5: assert property (@(posedge clk) disable iff (rst)
    !((|(rx_status & ~rx_mask)) || (|(tx_status & ~tx_mask))) |=> !irq);
  p_rdata_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> (reg_rdata == '0));
endmodule

bind evt_irq_unit evt_irq_unit_chk #(
  .RX_N(RX_N), .TX_N(TX_N), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) u_chk (.*);

// File: tb/evt_irq_unit_test.sv
module evt_irq_unit_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_en = 1'b0, tx_en = 1'b0;
  logic [8:0] rx_evt = '0;
  logic [2:0] tx_evt = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [8:0] m_rx_st, m_rx_mk;
  logic [2:0] m_tx_st, m_tx_mk;
  logic [15:0] m_rdata;
  logic m_irq;

  always #10 clk = ~clk;

  evt_irq_unit uut (
    .clk(clk), .rst(rst), .rx_en(rx_en), .tx_en(tx_en), .rx_evt(rx_evt), .tx_evt(tx_evt),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  function automatic logic [15:0] model_read(input int a);
    case (a)
      0, 2: return {7'd0, m_rx_st};
      1: return {7'd0, m_rx_mk};
      4, 6: return {13'd0, m_tx_st};
      5: return {13'd0, m_tx_mk};
      default: return 16'd0;
    endcase
  endfunction

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    logic [8:0] nrx_st, nrx_mk;
    logic [2:0] ntx_st, ntx_mk;
    if (rst) begin
      m_rx_st = '0; m_rx_mk = '1; m_tx_st = '0; m_tx_mk = '1;
      m_irq = 1'b0; m_rdata = '0;
    end else begin
      m_irq = ((m_rx_st & ~m_rx_mk) != 0) || ((m_tx_st & ~m_tx_mk) != 0);
      m_rdata = reg_rd ? model_read(int'(reg_addr)) : 16'd0;
      nrx_st = m_rx_st; nrx_mk = m_rx_mk; ntx_st = m_tx_st; ntx_mk = m_tx_mk;
      if (reg_wr) begin
        case (int'(reg_addr))
          0: nrx_st = nrx_st & ~reg_wdata[8:0];
          1: nrx_mk = reg_wdata[8:0];
          2: nrx_st = nrx_st | reg_wdata[8:0];
          4: ntx_st = ntx_st & ~reg_wdata[2:0];
          5: ntx_mk = reg_wdata[2:0];
          6: ntx_st = ntx_st | reg_wdata[2:0];
          default: ;
        endcase
      end
      if (rx_en) nrx_st = nrx_st | rx_evt;
      if (tx_en) ntx_st = ntx_st | tx_evt;
      m_rx_st = nrx_st; m_rx_mk = nrx_mk; m_tx_st = ntx_st; m_tx_mk = ntx_mk;
    end
  end

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (irq !== m_irq) begin
        errors++;
        $display("FAIL R5 cycle irq: actual=%0b expected=%0b at %0t", irq, m_irq, $time);
      end
      checks++;
      if (reg_rdata !== m_rdata) begin
        errors++;
        $display("FAIL R8 cycle rdata: actual=%h expected=%h at %0t", reg_rdata, m_rdata, $time);
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input int a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd_reg(input int a, output logic [15:0] v);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = 3'(a);
    @(negedge clk);
    v = reg_rdata;
    reg_rd = 1'b0;
  endtask

  task automatic pulse_rx(input logic [8:0] b);
    @(negedge clk); rx_evt = b;
    @(negedge clk); rx_evt = '0;
  endtask

  task automatic pulse_tx(input logic [2:0] b);
    @(negedge clk); tx_evt = b;
    @(negedge clk); tx_evt = '0;
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    rd_reg(1, v); chk("R4 rx mask reset", v, 16'h01FF);
    rd_reg(5, v); chk("R4 tx mask reset", v, 16'h0007);
    rd_reg(0, v); chk("R4 rx status reset", v, 16'h0000);
    rd_reg(4, v); chk("R4 tx status reset", v, 16'h0000);
    chk("R4 irq reset", {15'd0, irq}, 16'h0000);

    rx_en = 1'b1;
    pulse_rx(9'h001);
    rd_reg(0, v); chk("R1 R9 rx frame bit", v, 16'h0001);
    rd_reg(2, v); chk("R3 force view equals status", v, 16'h0001);
    chk("R4 masked bit gives no irq", {15'd0, irq}, 16'h0000);

    wr_reg(1, 16'h01FE);
    chk("R5 irq one cycle late", {15'd0, irq}, 16'h0000);
    @(negedge clk);
    chk("R5 irq after unmask", {15'd0, irq}, 16'h0001);

    wr_reg(0, 16'h0000);
    rd_reg(0, v); chk("R2 zero write keeps bit", v, 16'h0001);
    wr_reg(0, 16'h0001);
    rd_reg(0, v); chk("R2 w1c clears bit", v, 16'h0000);
    chk("R2 irq drops after clear", {15'd0, irq}, 16'h0000);

    pulse_rx(9'h020);
    rx_en = 1'b0;
    pulse_rx(9'h008);
    rd_reg(0, v); chk("R6 disabled event ignored, old bit kept", v, 16'h0020);
    wr_reg(0, 16'h0020);

    wr_reg(2, 16'h0100);
    rd_reg(0, v); chk("R3 force top rx bit while disabled", v, 16'h0100);
    wr_reg(0, 16'h0100);

    wr_reg(6, 16'h0004);
    rd_reg(4, v); chk("R3 tx force seen at status", v, 16'h0004);
    rd_reg(6, v); chk("R3 tx force view", v, 16'h0004);
    wr_reg(5, 16'h0003);
    @(negedge clk);
    chk("R5 tx unmasked forced bit", {15'd0, irq}, 16'h0001);
    wr_reg(4, 16'h0004);
    rd_reg(6, v); chk("R3 status clear seen at force view", v, 16'h0000);

    tx_en = 1'b1;
    pulse_tx(3'b001);
    rd_reg(4, v); chk("R1 R9 tx frame bit", v, 16'h0001);
    wr_reg(4, 16'h0001);

    rx_en = 1'b1;
    @(negedge clk);
    rx_evt = 9'h004; reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 16'h0004;
    @(negedge clk);
    rx_evt = '0; reg_wr = 1'b0; reg_wdata = '0;
    rd_reg(0, v); chk("R7 set wins over clear", v, 16'h0004);
    wr_reg(0, 16'h0004);
    rd_reg(0, v); chk("R2 clear after collision", v, 16'h0000);

    wr_reg(1, 16'hFFFF);
    rd_reg(1, v); chk("R8 reserved mask bits read zero", v, 16'h01FF);
    wr_reg(3, 16'hFFFF);
    rd_reg(3, v); chk("R8 unused address 3", v, 16'h0000);
    rd_reg(7, v); chk("R8 unused address 7", v, 16'h0000);
    wr_reg(2, 16'hFE00);
    rd_reg(0, v); chk("R8 reserved force bits ignored", v, 16'h0000);
    @(negedge clk);
    chk("R8 rdata zero without read", reg_rdata, 16'h0000);

    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      rx_en = 1'($urandom);
      tx_en = 1'($urandom);
      rx_evt = (($urandom % 4) == 0) ? 9'($urandom) : 9'h000;
      tx_evt = (($urandom % 4) == 0) ? 3'($urandom) : 3'h0;
      reg_wr = (($urandom % 3) == 0);
      reg_rd = 1'($urandom);
      reg_addr = 3'($urandom);
      reg_wdata = 16'($urandom);
    end
    @(negedge clk);
    rx_evt = '0; tx_evt = '0; reg_wr = 1'b0; reg_rd = 1'b0;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule